// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is the control engine of one DMA channel. Software places a chain of descriptors in a descriptor memory, sets the initial consumer cycle state, enables list mode and rings the doorbell with the channel's index. The walker then reads descriptors one 32-bit word at a time through a synchronous read port. For every data element it hands one transfer command (source, destination, byte count) to a downstream data mover over a valid/ready handshake.

Each descriptor carries a cycle bit. A descriptor belongs to the walker only while that bit matches the walker's consumer cycle state. When the bits differ, the walker stops and reports that it has run out of work. Link elements redirect the walk to a new list address and can flip the consumer cycle state, so one ring of descriptors can be reused on every pass. A data element that requests an interrupt ends the walk: once the mover acknowledges that transfer, the walker pulses done. A failed descriptor read pulses abort and halts the channel.

Top module: `llw_walker`

## Requirements
- R1: After reset, chan_status is 0 (idle), cycle_state is 0, and cmd_valid and mem_req are low.
- R2: A doorbell write starts the channel only when doorbell_ch equals the CH_ID parameter, cfg_list_en is 1 and the channel is not running. On start, chan_status becomes 1 (running), cycle_state takes cfg_cycle_init, and the first read is at list_base. A doorbell that fails any of these conditions causes no memory read and leaves chan_status unchanged.
- R3: A data element is six words at byte offsets 0 (control), 4 (byte count), 8/12 (source low/high) and 16/20 (destination low/high). The command carries exactly these values.
- R4: Control word bits: bit 0 is the cycle bit, bit 1 is toggle-cycle, bit 2 marks a link element, bit 3 is the local interrupt request and bit 4 is the remote interrupt request.
- R5: If the cycle bit of a control word differs from cycle_state, no command is issued, chan_status becomes 2 (stopped) and reading ends.
- R6: After a data element with neither interrupt bit set has been accepted by the mover, the next control word is read 24 bytes further on.
- R7: A link element supplies the next list address from its words at offsets 8 (low) and 12 (high). The next read is the control word at that address. If toggle-cycle is set, cycle_state is inverted.
- R8: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_src, cmd_dst and cmd_size stay unchanged.
- R9: After a data element with either interrupt bit set is accepted, the walker waits for xfer_ack. It then raises done_pulse for exactly one cycle and sets chan_status to 3 (done). done_pulse and abort_pulse are never high together.
- R10: A read answered with mem_err raises abort_pulse for one cycle, sets chan_status to 4 (halted), and no further reads follow.
- R11: A doorbell that arrives while the channel is running is ignored. The walk continues from its current position.
- R12: mem_req is never high in two consecutive cycles. Read data and mem_err are taken in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| doorbell_wr | input | 1 | Doorbell write strobe |
| doorbell_ch | input | CH_W | Channel index written to the doorbell |
| cfg_cycle_init | input | 1 | Consumer cycle state loaded on start |
| cfg_list_en | input | 1 | List mode enable |
| list_base | input | 64 | Byte address of the first descriptor |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 64 | Byte address of the word requested |
| mem_rdata | input | 32 | Read data, one cycle after request |
| mem_err | input | 1 | Read error, one cycle after request |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Mover accepts the command |
| cmd_src | output | 64 | Source address |
| cmd_dst | output | 64 | Destination address |
| cmd_size | output | 32 | Byte count |
| xfer_ack | input | 1 | Mover finished the interrupting transfer |
| chan_status | output | 3 | 0 idle, 1 running, 2 stopped, 3 done, 4 halted |
| cycle_state | output | 1 | Current consumer cycle state |
| done_pulse | output | 1 | One-cycle completion pulse |
| abort_pulse | output | 1 | One-cycle abort pulse |

## Verification
The interesting collision is a second doorbell arriving while a command is parked on a low cmd_ready. At that moment the walker is inside a walk and is also seeing a valid start request, so it must decide between restarting and continuing. The bench holds the mover stalled, rings the doorbell again with a different list base, and then releases the mover with a ready pattern that drops every few cycles. The result is judged by comparing every issued command and every read address with values computed from the descriptor table. The bench also confirms that the stalled command never changed while it waited.

// File: rtl/llw_pkg.sv
package llw_pkg;
    localparam int WORD_W     = 32;
    localparam int PTR_W      = 64;
    localparam int ELEM_WORDS = 6;
    localparam int IDX_W      = $clog2(ELEM_WORDS);

    // control word bit positions
    localparam int CB_CYCLE  = 0;
    localparam int CB_TOGGLE = 1;
    localparam int CB_LINK   = 2;
    localparam int CB_LIE    = 3;
    localparam int CB_RIE    = 4;

    // word slots inside an element
    localparam int SLOT_CTRL   = 0;
    localparam int SLOT_SIZE   = 1;
    localparam int SLOT_SRC_LO = 2;
    localparam int SLOT_SRC_HI = 3;
    localparam int SLOT_DST_LO = 4;
    localparam int SLOT_DST_HI = 5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_STOP = 3'd2,
        ST_DONE = 3'd3,
        ST_HALT = 3'd4
    } chan_status_e;

    typedef enum logic [3:0] {
        W_IDLE,
        W_CTRL,
        W_CHK,
        W_LINK,
        W_JUMP,
        W_BODY,
        W_LOAD,
        W_ISSUE,
        W_ACK
    } walk_state_e;
endpackage

// File: rtl/llw_fetch.sv
module llw_fetch #(
    parameter int PTR_W  = 64,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PTR_W-1:0]  base_i,
    input  logic [IDX_W-1:0]  first_i,
    input  logic [IDX_W-1:0]  last_i,
    output logic              mem_req_o,
    output logic [PTR_W-1:0]  mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_err_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int BYTE_SH = $clog2(WORD_W / 8);

    typedef enum logic [1:0] {F_IDLE, F_REQ, F_RSP} fst_e;

    typedef struct packed {
        fst_e             st;
        logic [PTR_W-1:0] base;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
    } fq_t;

    fq_t q, d;

    always_comb begin
        d       = q;
        wr_en_o = 1'b0;
        done_o  = 1'b0;
        err_o   = 1'b0;
        unique case (q.st)
            F_IDLE: begin
                if (start_i) begin
                    d.base = base_i;
                    d.idx  = first_i;
                    d.last = last_i;
                    d.st   = F_REQ;
                end
            end
            F_REQ: d.st = F_RSP;
            F_RSP: begin
                if (mem_err_i) begin
                    err_o = 1'b1;
                    d.st  = F_IDLE;
                end else begin
                    wr_en_o = 1'b1;
                    if (q.idx == q.last) begin
                        done_o = 1'b1;
                        d.st   = F_IDLE;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = F_REQ;
                    end
                end
            end
            default: d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req_o  = (q.st == F_REQ);
    assign mem_addr_o = q.base + (PTR_W'(q.idx) << BYTE_SH);
    assign wr_idx_o   = q.idx;
    assign wr_data_o  = mem_rdata_i;

    // R12: a request is always followed by a response cycle
    p_req_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);
endmodule

// File: rtl/llw_cmd_port.sv
module llw_cmd_port #(
    parameter int PTR_W  = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PTR_W-1:0]  src_i,
    input  logic [PTR_W-1:0]  dst_i,
    input  logic [WORD_W-1:0] size_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [PTR_W-1:0]  cmd_src_o,
    output logic [PTR_W-1:0]  cmd_dst_o,
    output logic [WORD_W-1:0] cmd_size_o,
    output logic              fire_o
);
    typedef struct packed {
        logic              valid;
        logic [PTR_W-1:0]  src;
        logic [PTR_W-1:0]  dst;
        logic [WORD_W-1:0] size;
    } cq_t;

    cq_t q, d;

    always_comb begin
        d = q;
        if (q.valid && cmd_ready_i) d.valid = 1'b0;
        if (load_i) begin
            d.valid = 1'b1;
            d.src   = src_i;
            d.dst   = dst_i;
            d.size  = size_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_valid_o = q.valid;
    assign cmd_src_o   = q.src;
    assign cmd_dst_o   = q.dst;
    assign cmd_size_o  = q.size;
    assign fire_o      = q.valid && cmd_ready_i;

    // R8: a stalled command is held unchanged
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_src_o)
            && $stable(cmd_dst_o) && $stable(cmd_size_o)));
endmodule

// File: rtl/llw_walker.sv
module llw_walker
    import llw_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int CH_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              doorbell_wr,
    input  logic [CH_W-1:0]   doorbell_ch,
    input  logic              cfg_cycle_init,
    input  logic              cfg_list_en,
    input  logic [PTR_W-1:0]  list_base,
    output logic              mem_req,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [PTR_W-1:0]  cmd_src,
    output logic [PTR_W-1:0]  cmd_dst,
    output logic [WORD_W-1:0] cmd_size,
    input  logic              xfer_ack,
    output logic [2:0]        chan_status,
    output logic              cycle_state,
    output logic              done_pulse,
    output logic              abort_pulse
);
    localparam int ELEM_BYTES = ELEM_WORDS * WORD_W / 8;
    localparam logic [CH_W-1:0] MY_CH = CH_W'(CH_ID);

    typedef struct packed {
        walk_state_e                        st;
        logic [PTR_W-1:0]                   ptr;
        logic                               cyc;
        logic [ELEM_WORDS-1:0][WORD_W-1:0]  words;
        chan_status_e                       status;
        logic                               done;
        logic                               abort;
        logic                               fstart;
        logic [IDX_W-1:0]                   ffirst;
        logic [IDX_W-1:0]                   flast;
    } wq_t;

    wq_t q, d;

    logic              f_wr, f_done, f_err, cmd_fire, cmd_load;
    logic [IDX_W-1:0]  f_idx;
    logic [WORD_W-1:0] f_data;
    logic [WORD_W-1:0] ctrl_w;

    assign ctrl_w = q.words[SLOT_CTRL];

    llw_fetch #(.PTR_W(PTR_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (q.fstart),
        .base_i     (q.ptr),
        .first_i    (q.ffirst),
        .last_i     (q.flast),
        .mem_req_o  (mem_req),
        .mem_addr_o (mem_addr),
        .mem_rdata_i(mem_rdata),
        .mem_err_i  (mem_err),
        .wr_en_o    (f_wr),
        .wr_idx_o   (f_idx),
        .wr_data_o  (f_data),
        .done_o     (f_done),
        .err_o      (f_err)
    );

    llw_cmd_port #(.PTR_W(PTR_W), .WORD_W(WORD_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cmd_load),
        .src_i      ({q.words[SLOT_SRC_HI], q.words[SLOT_SRC_LO]}),
        .dst_i      ({q.words[SLOT_DST_HI], q.words[SLOT_DST_LO]}),
        .size_i     (q.words[SLOT_SIZE]),
        .cmd_valid_o(cmd_valid),
        .cmd_ready_i(cmd_ready),
        .cmd_src_o  (cmd_src),
        .cmd_dst_o  (cmd_dst),
        .cmd_size_o (cmd_size),
        .fire_o     (cmd_fire)
    );

    always_comb begin
        d        = q;
        d.fstart = 1'b0;
        d.done   = 1'b0;
        d.abort  = 1'b0;
        cmd_load = 1'b0;

        if (f_wr && (int'(f_idx) < ELEM_WORDS)) d.words[f_idx] = f_data;

        unique case (q.st)
            W_IDLE: begin
                if (doorbell_wr && doorbell_ch == MY_CH && cfg_list_en) begin
                    d.ptr    = list_base;
                    d.cyc    = cfg_cycle_init;
                    d.status = ST_RUN;
                    d.fstart = 1'b1;
                    d.ffirst = IDX_W'(SLOT_CTRL);
                    d.flast  = IDX_W'(SLOT_CTRL);
                    d.st     = W_CTRL;
                end
            end
            W_CTRL, W_LINK, W_BODY: begin
                if (f_err) begin
                    d.abort  = 1'b1;
                    d.status = ST_HALT;
                    d.st     = W_IDLE;
                end else if (f_done) begin
                    d.st = (q.st == W_CTRL) ? W_CHK :
                           (q.st == W_LINK) ? W_JUMP : W_LOAD;
                end
            end
            W_CHK: begin
                d.fstart = 1'b1;
                if (ctrl_w[CB_CYCLE] != q.cyc) begin
                    d.fstart = 1'b0;
                    d.status = ST_STOP;
                    d.st     = W_IDLE;
                end else if (ctrl_w[CB_LINK]) begin
                    d.ffirst = IDX_W'(SLOT_SRC_LO);
                    d.flast  = IDX_W'(SLOT_SRC_HI);
                    d.st     = W_LINK;
                end else begin
                    d.ffirst = IDX_W'(SLOT_SIZE);
                    d.flast  = IDX_W'(SLOT_DST_HI);
                    d.st     = W_BODY;
                end
            end
            W_JUMP: begin
                d.ptr    = {q.words[SLOT_SRC_HI], q.words[SLOT_SRC_LO]};
                d.cyc    = q.cyc ^ ctrl_w[CB_TOGGLE];
                d.fstart = 1'b1;
                d.ffirst = IDX_W'(SLOT_CTRL);
                d.flast  = IDX_W'(SLOT_CTRL);
                d.st     = W_CTRL;
            end
            W_LOAD: begin
                cmd_load = 1'b1;
                d.st     = W_ISSUE;
            end
            W_ISSUE: begin
                if (cmd_fire) begin
                    if (ctrl_w[CB_LIE] || ctrl_w[CB_RIE]) begin
                        d.st = W_ACK;
                    end else begin
                        d.ptr    = q.ptr + PTR_W'(ELEM_BYTES);
                        d.fstart = 1'b1;
                        d.ffirst = IDX_W'(SLOT_CTRL);
                        d.flast  = IDX_W'(SLOT_CTRL);
                        d.st     = W_CTRL;
                    end
                end
            end
            W_ACK: begin
                if (xfer_ack) begin
                    d.done   = 1'b1;
                    d.status = ST_DONE;
                    d.st     = W_IDLE;
                end
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign chan_status = q.status;
    assign cycle_state = q.cyc;
    assign done_pulse  = q.done;
    assign abort_pulse = q.abort;

    // R9: completion and abort never coincide
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_pulse && abort_pulse));
    // R9: done lasts a single cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    // R10: abort lasts a single cycle and no read follows it
    p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> (!abort_pulse && !mem_req));
    // R5: a stopped channel presents no command
    p_stop_no_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_status == 3'd2) |-> !cmd_valid);
endmodule

// File: tb/llw_walker_tb.sv
`timescale 1ns/1ps
module llw_walker_tb;
    localparam logic [2:0] S_IDLE = 3'd0, S_RUN = 3'd1, S_STOP = 3'd2,
                           S_DONE = 3'd3, S_HALT = 3'd4;

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] dst;
        logic [31:0] size;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{64'h0000_0001_1000_0000, 64'h0000_0002_2000_0000, 32'h0000_0100},
        '{64'h0000_0001_1000_0100, 64'h0000_0002_2000_0400, 32'h0000_0040},
        '{64'hABCD_0000_0000_0010, 64'h1234_0000_0000_0020, 32'h0000_0004},
        '{64'h0000_0000_FFFF_FFFC, 64'h8000_0000_0000_0000, 32'h0001_0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic doorbell_wr = 1'b0;
    logic [2:0] doorbell_ch = '0;
    logic cfg_cycle_init = 1'b0, cfg_list_en = 1'b0;
    logic [63:0] list_base = '0;
    logic mem_req, mem_err = 1'b0;
    logic [63:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic cmd_valid, cmd_ready = 1'b0;
    logic [63:0] cmd_src, cmd_dst;
    logic [31:0] cmd_size;
    logic xfer_ack = 1'b0;
    logic [2:0] chan_status;
    logic cycle_state, done_pulse, abort_pulse;

    always #2 clk = ~clk;

    llw_walker #(.CH_W(3), .CH_ID(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .doorbell_wr(doorbell_wr), .doorbell_ch(doorbell_ch),
        .cfg_cycle_init(cfg_cycle_init), .cfg_list_en(cfg_list_en), .list_base(list_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
        .cmd_size(cmd_size), .xfer_ack(xfer_ack), .chan_status(chan_status),
        .cycle_state(cycle_state), .done_pulse(done_pulse), .abort_pulse(abort_pulse)
    );

    // descriptor memory model: synchronous read
    logic [31:0] mem [0:1023];
    logic [63:0] err_addr = 64'hFFFF_FFFF_FFFF_FFFF;
    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= mem[mem_addr[11:2]];
            mem_err   <= (mem_addr == err_addr);
        end
    end

    // mover ready pattern: 0 low, 1 high, 2 drops periodically
    int ready_mode = 0;
    int rcnt = 0;
    initial forever begin
        @(posedge clk); #1;
        rcnt++;
        cmd_ready = (ready_mode == 1) || (ready_mode == 2 && (rcnt % 3) != 0);
    end

    // observation logs, sampled at the falling edge
    int nchk = 0, nerr = 0;
    int ncmd = 0, nrd = 0, ndone = 0, nabort = 0, hold_err = 0, consec = 0;
    logic [63:0] log_src [0:15];
    logic [63:0] log_dst [0:15];
    logic [31:0] log_size [0:15];
    logic [63:0] rd_log [0:63];
    logic pv = 1'b0, pr = 1'b0, preq = 1'b0;
    logic [63:0] psrc, pdst;
    logic [31:0] psize;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && cmd_ready && ncmd < 16) begin
                log_src[ncmd] = cmd_src; log_dst[ncmd] = cmd_dst; log_size[ncmd] = cmd_size;
                ncmd++;
            end
            if (pv && !pr && !(cmd_valid && cmd_src == psrc && cmd_dst == pdst && cmd_size == psize))
                hold_err++;
            if (mem_req) begin
                if (nrd < 64) rd_log[nrd] = mem_addr;
                nrd++;
                if (preq) consec++;
            end
            if (done_pulse) ndone++;
            if (abort_pulse) nabort++;
        end
        pv = cmd_valid; pr = cmd_ready; psrc = cmd_src; pdst = cmd_dst; psize = cmd_size;
        preq = mem_req;
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        ncmd = 0; nrd = 0; ndone = 0; nabort = 0;
    endtask

    task automatic ring(input logic [2:0] ch, input logic en, input logic cyc, input logic [63:0] base);
        @(posedge clk); #1;
        doorbell_wr = 1'b1; doorbell_ch = ch; cfg_list_en = en; cfg_cycle_init = cyc; list_base = base;
        @(posedge clk); #1;
        doorbell_wr = 1'b0;
    endtask

    task automatic put_data(input logic [63:0] a, input logic [31:0] ctrl, input vec_t v);
        mem[a[11:2]]     = ctrl;
        mem[a[11:2] + 1] = v.size;
        mem[a[11:2] + 2] = v.src[31:0];
        mem[a[11:2] + 3] = v.src[63:32];
        mem[a[11:2] + 4] = v.dst[31:0];
        mem[a[11:2] + 5] = v.dst[63:32];
    endtask

    task automatic put_link(input logic [63:0] a, input logic [31:0] ctrl, input logic [63:0] nxt);
        mem[a[11:2]]     = ctrl;
        mem[a[11:2] + 1] = 32'h0;
        mem[a[11:2] + 2] = nxt[31:0];
        mem[a[11:2] + 3] = nxt[63:32];
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cmds(input int n);
        for (int i = 0; i < 2000 && ncmd < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(posedge clk); #1; xfer_ack = 1'b1;
        @(posedge clk); #1; xfer_ack = 1'b0;
    endtask

    bit finished = 1'b0;
    initial begin
        #(200000 * 4);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        vec_t vb0, vb1, vd;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        wait_cycles(3);
        // R1: reset state
        check(chan_status == S_IDLE && !cmd_valid && !mem_req && !cycle_state, "R1",
              {60'h0, cycle_state, chan_status}, 64'h0);
        rst_n = 1'b1;
        wait_cycles(2);

        // R2: doorbells that must be ignored
        ring(3'd1, 1'b1, 1'b1, 64'h100);
        ring(3'd0, 1'b0, 1'b1, 64'h100);
        wait_cycles(10);
        check(nrd == 0 && chan_status == S_IDLE, "R2 ignored doorbell", nrd, 0);

        // table-driven list: four data elements, the last requests a local interrupt
        for (int k = 0; k < 4; k++)
            put_data(64'h100 + 64'(24 * k), (k == 3) ? 32'h9 : 32'h1, VECS[k]);
        clear_logs();
        ready_mode = 0;
        ring(3'd0, 1'b1, 1'b1, 64'h100);
        wait_cycles(30);
        check(chan_status == S_RUN, "R2 running", chan_status, S_RUN);
        check(cycle_state == 1'b1, "R2 cycle init", cycle_state, 1);
        check(rd_log[0] == 64'h100, "R2 first read", rd_log[0], 64'h100);
        check(nrd == 6 && rd_log[5] == 64'h114, "R3 element words", rd_log[5], 64'h114);
        check(cmd_valid == 1'b1, "R8 stalled valid", cmd_valid, 1);
        // R11: second doorbell while running
        ring(3'd0, 1'b1, 1'b0, 64'h800);
        ready_mode = 2;
        wait_cmds(4);
        wait_cycles(10);
        check(ndone == 0 && chan_status == S_RUN, "R9 waits for ack", ndone, 0);
        for (int k = 0; k < 4; k++) begin
            check(log_src[k] == VECS[k].src, "R3 src", log_src[k], VECS[k].src);
            check(log_dst[k] == VECS[k].dst && log_size[k] == VECS[k].size, "R3 dst/size",
                  log_dst[k], VECS[k].dst);
            check(rd_log[6 * k] == 64'h100 + 64'(24 * k), "R6 stride", rd_log[6 * k],
                  64'h100 + 64'(24 * k));
        end
        check(ncmd == 4 && cycle_state == 1'b1, "R11 walk unaffected", ncmd, 4);
        check(hold_err == 0, "R8 hold", hold_err, 0);
        pulse_ack();
        wait_cycles(3);
        check(ndone == 1 && chan_status == S_DONE, "R9 done", {ndone[31:0], 29'h0, chan_status},
              {32'h1, 32'h3});

        // link with toggle-cycle, R4 bit use
        vb0 = '{64'h0000_1111_AAAA_0000, 64'h0000_2222_BBBB_0000, 32'h40};
        vb1 = '{64'h0000_3333_CCCC_0000, 64'h0000_4444_DDDD_0000, 32'h80};
        put_data(64'h400, 32'h1, vb0);
        put_link(64'h418, 32'h7, 64'h600);
        put_data(64'h600, 32'h10, vb1);
        clear_logs();
        ready_mode = 1;
        ring(3'd0, 1'b1, 1'b1, 64'h400);
        wait_cmds(2);
        wait_cycles(4);
        check(cycle_state == 1'b0, "R7 toggle", cycle_state, 0);
        check(log_src[1] == vb1.src && log_size[1] == vb1.size, "R7 follow link", log_src[1], vb1.src);
        check(rd_log[6] == 64'h418 && rd_log[7] == 64'h420 && rd_log[8] == 64'h424, "R7 link words",
              rd_log[8], 64'h424);
        check(rd_log[9] == 64'h600, "R7 next list", rd_log[9], 64'h600);
        pulse_ack();
        wait_cycles(3);
        check(ndone == 1 && nabort == 0 && chan_status == S_DONE, "R9 remote irq", chan_status, S_DONE);

        // ownership mismatch
        put_data(64'h800, 32'h0, vb0);
        clear_logs();
        ring(3'd0, 1'b1, 1'b1, 64'h800);
        wait_cycles(20);
        check(chan_status == S_STOP && ncmd == 0 && !cmd_valid, "R5 stop", chan_status, S_STOP);
        check(nrd == 1, "R5 no more reads", nrd, 1);

        // read error on the second element
        vd = '{64'h5, 64'h6, 32'h7};
        put_data(64'hA00, 32'h1, vd);
        put_data(64'hA18, 32'h1, vd);
        err_addr = 64'hA18;
        clear_logs();
        ring(3'd0, 1'b1, 1'b1, 64'hA00);
        wait_cycles(40);
        check(nabort == 1 && chan_status == S_HALT, "R10 abort", chan_status, S_HALT);
        check(ncmd == 1 && ndone == 0, "R10 one command", ncmd, 1);
        nrd = 0;
        wait_cycles(10);
        check(nrd == 0, "R10 quiet", nrd, 0);
        err_addr = 64'hFFFF_FFFF_FFFF_FFFF;

        check(consec == 0, "R12 request spacing", consec, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule